// File: doc/BRIEF.md
# DMA Transfer Counter with Reload

This block holds the byte count for a DMA transfer in a SCSI-style host adapter. Software programs a 24-bit count through three byte-wide registers. Those writes land in a shadow copy. A command that carries the DMA flag copies the shadow into the live counter.

When the command opcode is "transfer information", the block works out how many bytes to move. That number is the smaller of the counter and a limit. The limit is the remaining-length input in normal mode, or the command-buffer capacity while commands are being collected. The block then hands out that many single-byte beats to a DMA engine over a request/acknowledge pair, decrementing the live counter on every accepted beat. When the last beat is taken it reports terminal count and raises a service cause.

A programmed count of zero stands for 65536 bytes. The high count byte reads back a fixed identifier until software writes it for the first time after reset.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset the live counter is zero, the terminal-count bit (status address 4, bit 0) and the service bit (status address 4, bit 1) are clear, `dma_req` is low, and address 2 reads `CHIP_ID`.
- R2: Writes to addresses 0, 1 and 2 set bits 7:0, 15:8 and 23:16 of the shadow count and leave the live counter, read back at those addresses, unchanged. A write to address 3 with bit 7 set copies the whole shadow into the live counter. A write to address 3 with bit 7 clear does not copy it.
- R3: Address 2 reads `CHIP_ID` until address 2 has been written once after reset. From then on it reads live bits 23:16. Only reset returns it to the identifier.
- R4: A write to any of addresses 0 to 2 clears the terminal-count bit.
- R5: A write of 0x90 to address 3 (bit 7 = DMA flag, bits 6:0 = 0x10 transfer opcode) reloads the counter and starts a transfer. The transfer length is min(count, `remain_len`), where a count of 0 counts as 65536. The terminal-count bit is clear on the cycle after the start.
- R6: If `cmd_collect` is high when the transfer starts, the length is min(count, `CMDBUF_CAP`) and `remain_len` is ignored.
- R7: `dma_req` is high while beats remain. Each cycle with `dma_req` and `dma_ack` both high moves one byte and decrements the live counter by one, modulo 2^24.
- R8: On the clock edge that accepts the last beat, the terminal-count bit and the service bit are set and the live counter becomes zero. `dma_req` is low from then on. A zero-length transfer completes on the edge after the start.
- R9: Writing address 4 with bit 1 set clears the service bit. An opcode 0x10 command without the DMA flag starts no transfer.
- R10: Whatever the transfer logic does on an edge, a host write on that same edge takes effect over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Register address (0-2 count bytes, 3 command, 4 status) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| cmd_collect | input | 1 | Command-collect mode selects the buffer capacity as the limit |
| remain_len | input | REM_W | Bytes still to be moved for the current request |
| dma_req | output | 1 | Beat request to the DMA engine |
| dma_ack | input | 1 | DMA engine accepts the requested beat |
| tc_out | output | 1 | Terminal-count status |
| svc_out | output | 1 | Bus-service cause |

## Verification
The bench builds the block with `CHIP_ID` = 0x5C, `CMDBUF_CAP` = 16 and `REM_W` = 24. With a 24-bit `remain_len`, a zero count can be tested over its full 65536-beat length. The small buffer capacity lets a 40-byte count be clipped to 16 in collect mode. The non-default identifier shows that the high-byte read-back really comes from the parameter.

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter logic [7:0] CHIP_ID = 8'hA2,
  parameter int CMDBUF_CAP = 16,
  parameter int REM_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [2:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             cmd_collect,
  input  logic [REM_W-1:0] remain_len,
  output logic             dma_req,
  input  logic             dma_ack,
  output logic             tc_out,
  output logic             svc_out
);
  localparam int CNT_W = 24;
  localparam int LEN_W = ((REM_W > CNT_W) ? REM_W : CNT_W) + 1;
  localparam logic [LEN_W-1:0] ZERO_LEN = LEN_W'(1 << 16);
  localparam logic [6:0] OP_XFER = 7'h10;

  logic [CNT_W-1:0] shadow, live;
  logic [LEN_W-1:0] beats;
  logic hi_wr, tc, svc, active;

  wire cmd_wr   = host_we && host_addr == 3'd3;
  wire dma_cmd  = cmd_wr && host_wdata[7];
  wire start    = dma_cmd && host_wdata[6:0] == OP_XFER;
  wire beat     = dma_req && dma_ack;
  wire last     = active && (beats == '0 || (beat && beats == LEN_W'(1)));

  wire [LEN_W-1:0] base  = (shadow == '0) ? ZERO_LEN : LEN_W'(shadow);
  wire [LEN_W-1:0] limit = cmd_collect ? LEN_W'(CMDBUF_CAP) : LEN_W'(remain_len);
  wire [LEN_W-1:0] xfer_len = (base < limit) ? base : limit;

  assign dma_req = active && beats != '0;
  assign tc_out  = tc;
  assign svc_out = svc;

  always_comb begin
    case (host_addr)
      3'd0:    host_rdata = live[7:0];
      3'd1:    host_rdata = live[15:8];
      3'd2:    host_rdata = hi_wr ? live[23:16] : CHIP_ID;
      3'd4:    host_rdata = {6'b0, svc, tc};
      default: host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      live   <= '0;
      beats  <= '0;
      hi_wr  <= 1'b0;
      tc     <= 1'b0;
      svc    <= 1'b0;
      active <= 1'b0;
    end else begin
      if (last) begin
        tc     <= 1'b1;
        svc    <= 1'b1;
        live   <= '0;
        active <= 1'b0;
        beats  <= '0;
      end else if (beat) begin
        beats <= beats - LEN_W'(1);
        live  <= live - CNT_W'(1);
      end
      if (host_we) begin
        case (host_addr)
          3'd0: begin shadow[7:0]   <= host_wdata; tc <= 1'b0; end
          3'd1: begin shadow[15:8]  <= host_wdata; tc <= 1'b0; end
          3'd2: begin shadow[23:16] <= host_wdata; tc <= 1'b0; hi_wr <= 1'b1; end
          3'd4: if (host_wdata[1]) svc <= 1'b0;
          default: ;
        endcase
        if (dma_cmd) live <= shadow;
        if (start) begin
          beats  <= xfer_len;
          active <= 1'b1;
          tc     <= 1'b0;
        end
      end
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we && !active) |=> $stable(live));

  // R4
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr <= 3'd2) |=> !tc_out);

  // R5
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!tc_out && active));

  // R7
  beat_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && beats > LEN_W'(1) && !host_we) |=> live == $past(live) - CNT_W'(1));

  // R8
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !host_we) |=> (tc_out && svc_out && live == '0 && !dma_req));
endmodule

// File: tb/xfer_count_unit_tb.sv
module xfer_count_unit_tb_top;
  localparam logic [7:0] ID = 8'h5C;
  localparam int CAP = 16;

  logic clk = 0, rst_n = 0, host_we = 0, cmd_collect = 0, dma_ack = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [23:0] remain_len = 0;
  logic [7:0] host_rdata;
  logic dma_req, tc_out, svc_out;

  int checks = 0, fails = 0, cyc = 0;

  xfer_count_unit #(.CHIP_ID(ID), .CMDBUF_CAP(CAP), .REM_W(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_collect(cmd_collect),
    .remain_len(remain_len), .dma_req(dma_req), .dma_ack(dma_ack),
    .tc_out(tc_out), .svc_out(svc_out));

  always #10 clk = ~clk;

  // behavioural reference
  int m_sh, m_lv, m_bt;
  bit m_hw, m_tc, m_svc, m_act;

  always @(posedge clk) begin
    bit req, fin;
    int n, lim;
    fin = 0;
    if (!rst_n) begin
      m_sh = 0; m_lv = 0; m_bt = 0; m_hw = 0; m_tc = 0; m_svc = 0; m_act = 0;
    end else begin
      req = m_act && m_bt != 0;
      if (m_act) begin
        if (m_bt == 0) fin = 1;
        else if (req && dma_ack) begin
          m_bt--; m_lv = (m_lv - 1) & 24'hFFFFFF;
          if (m_bt == 0) fin = 1;
        end
      end
      if (fin) begin m_tc = 1; m_svc = 1; m_lv = 0; m_act = 0; end
      if (host_we) begin
        if (host_addr == 0) begin m_sh = (m_sh & 32'hFFFF00) | host_wdata; m_tc = 0; end
        if (host_addr == 1) begin m_sh = (m_sh & 32'hFF00FF) | (int'(host_wdata) << 8); m_tc = 0; end
        if (host_addr == 2) begin m_sh = (m_sh & 32'h00FFFF) | (int'(host_wdata) << 16); m_tc = 0; m_hw = 1; end
        if (host_addr == 4 && host_wdata[1]) m_svc = 0;
        if (host_addr == 3 && host_wdata[7]) begin
          m_lv = m_sh;
          if (host_wdata[6:0] == 7'h10) begin
            n = (m_lv == 0) ? 65536 : m_lv;
            lim = cmd_collect ? CAP : int'(remain_len);
            m_bt = (n < lim) ? n : lim;
            m_act = 1; m_tc = 0;
          end
        end
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      0: return m_lv[7:0];
      1: return m_lv[15:8];
      2: return m_hw ? m_lv[23:16] : ID;
      4: return {6'b0, m_svc, m_tc};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("R2 R3 rdata", host_rdata, exp_rd(host_addr));
      chk("R7 dma_req", dma_req, m_act && m_bt != 0);
      chk("R4 R8 tc", tc_out, m_tc);
      chk("R8 R9 svc", svc_out, m_svc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic set_cnt(input int c);
    wr(0, c[7:0]); wr(1, c[15:8]); wr(2, c[23:16]);
  endtask

  task automatic run(input int mode, input string tag, input int exp_n);
    int n = 0;
    int k = 0;
    while (dma_req && k < 100000) begin
      dma_ack = (mode == 0) || (k % 3 == 0);
      if (dma_ack) n++;
      k++;
      @(negedge clk);
    end
    dma_ack = 0;
    chk({tag, " beats"}, n, exp_n);
    chk("R8 tc at end", tc_out, 1);
    chk("R8 svc at end", svc_out, 1);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2, d); chk("R1 id after reset", d, ID);
    rd(4, d); chk("R1 status after reset", d, 0);
    chk("R1 dma_req after reset", dma_req, 0);

    wr(0, 8'h05);
    rd(0, d); chk("R2 live low unchanged", d, 0);
    rd(2, d); chk("R3 id before high write", d, ID);
    wr(1, 8'h00); wr(2, 8'h00);
    rd(2, d); chk("R3 high byte after write", d, 0);
    wr(3, 8'h00);
    rd(0, d); chk("R2 no reload without flag", d, 0);
    wr(3, 8'h80);
    rd(0, d); chk("R2 reload with flag", d, 5);

    wr(3, 8'h10);
    chk("R9 no start without flag", dma_req, 0);

    remain_len = 3;
    wr(3, 8'h90);
    rd(4, d); chk("R5 tc clear after start", d[0], 0);
    rd(0, d); chk("R5 live after start", d, 5);
    run(0, "R5 min remain", 3);
    rd(0, d); chk("R8 live zero", d, 0);

    wr(0, 8'h01);
    chk("R4 tc cleared by byte write", tc_out, 0);
    wr(4, 8'h02);
    chk("R9 svc cleared", svc_out, 0);

    set_cnt(24'h01020A);
    remain_len = 10;
    wr(3, 8'h90);
    rd(2, d); chk("R2 high byte reloaded", d, 8'h01);
    run(1, "R7 sparse ack", 10);

    set_cnt(40); cmd_collect = 1; remain_len = 1000;
    wr(3, 8'h90);
    cmd_collect = 0;
    run(0, "R6 collect cap", CAP);

    set_cnt(0); remain_len = 70000;
    wr(3, 8'h90);
    run(0, "R5 zero means 65536", 65536);

    set_cnt(8); remain_len = 0;
    wr(3, 8'h90);
    chk("R8 zero-length no req", dma_req, 0);
    chk("R8 zero-length tc not yet", tc_out, 0);
    @(negedge clk);
    chk("R8 zero-length tc", tc_out, 1);

    set_cnt(6); remain_len = 6;
    wr(3, 8'h90);
    dma_ack = 1;
    @(negedge clk); @(negedge clk);
    dma_ack = 0;
    rd(0, d); chk("R7 live decremented", d, 4);
    host_we = 1; host_addr = 3; host_wdata = 8'h80;
    dma_ack = 1;
    @(negedge clk);
    host_we = 0; dma_ack = 0;
    rd(0, d); chk("R10 host reload wins", d, 6);

    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    rd(2, d); chk("R3 id back after reset", d, ID);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule